// File: doc/BRIEF.md
# Power stage fault supervisor

This block watches over a four-channel switching output stage and decides, every clock, whether the power transistors may be driven. It takes per-half-bridge overcurrent flags, a junction temperature in whole degrees Celsius and a supply voltage in tenths of a volt. It also takes two active-low control inputs: one selects the low-power state and one forces high impedance. From these it drives one global output-enable, an active-low fault flag and an active-low thermal warning flag.

Overcurrent and thermal shutdown events remove the enable in the same cycle, through a path with no register, and set a fault latch. The latch is released only by a complete high, low, high sequence on the high-impedance input. Thermal shutdown has a hysteresis band: a release attempted inside that band latches the fault again at once. An undervoltage condition only holds the outputs off while it lasts and never sets the latch. An optional self-retry mode behaves as if the fault flag were tied back to the high-impedance input through a delay, with a programmable cycle count in place of that delay.

Top module: `pstage_guard`

## Requirements
- R1: While reset is high, out_en_o is 0, fault_n_o is 1 and twarn_n_o is 1. With good inputs, out_en_o becomes 1 one clock after reset is released.
- R2: When any bit of oc_flag_i is 1, or tj_degc_i is 150 or more, out_en_o is 0 in that same cycle, with no clock edge in between.
- R3: Such an event sets the fault latch, so fault_n_o is 0 from the next clock edge on. A one-cycle pulse is enough.
- R4: A latched fault stays set while hiz_n_i stays high. It is released only after hiz_n_i has been seen high, then low, then high again. Outputs re-enable on the same edge that completes the release.
- R5: If the fault condition is still present when the release completes, fault_n_o is 1 for exactly one cycle and the latch sets again on the next edge. out_en_o stays 0 throughout.
- R6: twarn_n_o is 0 from one clock after tj_degc_i exceeds 130 and is 1 for values of 130 or below. It has no effect on out_en_o.
- R7: After a trip at 150 degrees or more, the shutdown condition remains while tj_degc_i is above 125 and clears at 125 or below. A release done while it remains latches the fault again.
- R8: When vsup_dv_i is below 70, out_en_o is 0 from the next clock and no fault is latched. out_en_o returns to 1 one clock after vsup_dv_i is 70 or more.
- R9: When pdn_n_i or hiz_n_i is 0, out_en_o is 0 from the next clock.
- R10: With auto_retry_i at 1, a latched fault whose cause has gone keeps fault_n_o low for exactly max(retry_len_i,1)+1 cycles. After that the block releases itself and re-enables the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_flag_i | input | NHB (4) | Overcurrent flag, one per half bridge |
| tj_degc_i | input | TW (8) | Junction temperature, degrees Celsius |
| vsup_dv_i | input | VW (9) | Supply voltage, tenths of a volt |
| pdn_n_i | input | 1 | Low selects low-power state |
| hiz_n_i | input | 1 | Low forces high impedance; toggle releases faults |
| auto_retry_i | input | 1 | Emulate fault flag wired back to hiz_n_i |
| retry_len_i | input | RW (12) | Self-retry interval in cycles |
| out_en_o | output | 1 | Global output enable |
| fault_n_o | output | 1 | Low while a fault is latched |
| twarn_n_o | output | 1 | Low while temperature exceeds warning level |

## Verification
A fault release and a re-trip can land on the same edge. This happens when the release sequence completes while the overcurrent flag or the thermal hysteresis band is still active. The bench provokes both variants. It holds an overcurrent flag across the toggle, and it toggles while the temperature sits between 125 and 150. It judges them by a one-cycle high on fault_n_o followed by a low on the very next sample, while out_en_o never rises. A second collision, warning and shutdown both changing on one temperature step, is judged by sampling both flags on the same cycle.

// File: rtl/psg_pkg.sv
package psg_pkg;
  typedef enum logic [1:0] {
    FS_OK       = 2'd0,
    FS_NEED_HI  = 2'd1,
    FS_NEED_LO  = 2'd2,
    FS_NEED_REHI = 2'd3
  } flt_st_e;
endpackage

// File: rtl/psg_thermal.sv
module psg_thermal #(
  parameter int TW      = 8,
  parameter int WARN_C  = 130,
  parameter int TRIP_C  = 150,
  parameter int REARM_C = 125
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tj_i,
  output logic          trip_o,
  output logic          sd_q_o,
  output logic          twarn_n_o
);
  localparam logic [TW-1:0] WARN_V  = TW'(WARN_C);
  localparam logic [TW-1:0] TRIP_V  = TW'(TRIP_C);
  localparam logic [TW-1:0] REARM_V = TW'(REARM_C);

  logic sd_q, sd_d;

  assign trip_o = (tj_i >= TRIP_V);

  always_comb begin
    sd_d = sd_q;
    if (trip_o)               sd_d = 1'b1;
    else if (tj_i <= REARM_V) sd_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q      <= 1'b0;
      twarn_n_o <= 1'b1;
    end else begin
      sd_q      <= sd_d;
      twarn_n_o <= ~(tj_i > WARN_V);
    end
  end

  assign sd_q_o = sd_q;

  p_warn_r6: assert property (@(posedge clk) disable iff (rst)
    (tj_i > WARN_V) |=> !twarn_n_o);
  p_hyst_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sd_q && tj_i > REARM_V) |=> sd_q);
  p_hyst_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (tj_i <= REARM_V) |=> !sd_q);
endmodule

// File: rtl/psg_retry.sv
module psg_retry #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_i,
  input  logic          flt_i,
  input  logic [RW-1:0] len_i,
  output logic          pull_o
);
  logic [RW-1:0] cnt_q;
  logic          done;

  assign done   = (cnt_q != '0) && (cnt_q >= len_i);
  assign pull_o = auto_i & flt_i & ~done;

  always_ff @(posedge clk) begin
    if (rst || !flt_i || !auto_i) cnt_q <= '0;
    else if (!done)               cnt_q <= cnt_q + 1'b1;
  end

  p_pull_start_r10: assert property (@(posedge clk) disable iff (rst)
    (auto_i && $rose(flt_i)) |-> pull_o);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!auto_i) |-> !pull_o);
endmodule

// File: rtl/psg_latch.sv
module psg_latch
  import psg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cond_i,
  input  logic    hiz_i,
  output flt_st_e st_q_o,
  output flt_st_e st_d_o
);
  flt_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      FS_OK:        if (cond_i) st_d = hiz_i ? FS_NEED_LO : FS_NEED_HI;
      FS_NEED_HI:   if (hiz_i)  st_d = FS_NEED_LO;
      FS_NEED_LO:   if (!hiz_i) st_d = FS_NEED_REHI;
      FS_NEED_REHI: if (hiz_i)  st_d = FS_OK;
      default:                  st_d = FS_OK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= FS_OK;
    else     st_q <= st_d;
  end

  assign st_q_o = st_q;
  assign st_d_o = st_d;

  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_OK && cond_i) |=> (st_q != FS_OK));
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_OK && $past(st_q) != FS_OK) |->
      ($past(st_q) == FS_NEED_REHI && $past(hiz_i)));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q != FS_OK && st_q != FS_NEED_REHI) |=> (st_q != FS_OK));
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard
  import psg_pkg::*;
#(
  parameter int NHB     = 4,
  parameter int TW      = 8,
  parameter int VW      = 9,
  parameter int RW      = 12,
  parameter int WARN_C  = 130,
  parameter int TRIP_C  = 150,
  parameter int REARM_C = 125,
  parameter int UV_DV   = 70
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NHB-1:0] oc_flag_i,
  input  logic [TW-1:0]  tj_degc_i,
  input  logic [VW-1:0]  vsup_dv_i,
  input  logic           pdn_n_i,
  input  logic           hiz_n_i,
  input  logic           auto_retry_i,
  input  logic [RW-1:0]  retry_len_i,
  output logic           out_en_o,
  output logic           fault_n_o,
  output logic           twarn_n_o
);
  localparam logic [VW-1:0] UV_V = VW'(UV_DV);

  logic    therm_trip, sd_q, trip_now, fault_cond;
  logic    pull, hiz_eff, vs_ok, en_d, en_q;
  flt_st_e st_q, st_d;

  psg_thermal #(
    .TW(TW), .WARN_C(WARN_C), .TRIP_C(TRIP_C), .REARM_C(REARM_C)
  ) u_therm (
    .clk(clk), .rst(rst), .tj_i(tj_degc_i),
    .trip_o(therm_trip), .sd_q_o(sd_q), .twarn_n_o(twarn_n_o)
  );

  assign trip_now   = (|oc_flag_i) | therm_trip;
  assign fault_cond = trip_now | sd_q;
  assign hiz_eff    = hiz_n_i & ~pull;
  assign vs_ok      = (vsup_dv_i >= UV_V);

  psg_latch u_latch (
    .clk(clk), .rst(rst), .cond_i(fault_cond), .hiz_i(hiz_eff),
    .st_q_o(st_q), .st_d_o(st_d)
  );

  psg_retry #(.RW(RW)) u_retry (
    .clk(clk), .rst(rst), .auto_i(auto_retry_i),
    .flt_i(st_q != FS_OK), .len_i(retry_len_i), .pull_o(pull)
  );

  assign en_d = pdn_n_i & hiz_eff & vs_ok & (st_d == FS_OK) & ~fault_cond;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_d;
  end

  assign out_en_o  = en_q & ~trip_now;
  assign fault_n_o = (st_q == FS_OK);

  p_oc_kill_r2: assert property (@(posedge clk) disable iff (rst)
    (|oc_flag_i) |-> !out_en_o);
  p_oc_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (|oc_flag_i && fault_n_o) |=> !fault_n_o);
  p_uv_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!vs_ok) |=> !out_en_o);
  p_uv_nolatch_r8: assert property (@(posedge clk) disable iff (rst)
    (!vs_ok && !fault_cond && fault_n_o) |=> fault_n_o);
  p_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (!pdn_n_i || !hiz_n_i) |=> !out_en_o);
endmodule

// File: tb/test_pstage_guard.sv
module test_pstage_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] oc = '0;
  logic [7:0] tj = 8'd25;
  logic [8:0] vs = 9'd120;
  logic       pdn_n = 1'b1, hiz_n = 1'b1, auto_r = 1'b0;
  logic [11:0] rlen = 12'd5;
  logic       en, fn, wn;
  int         n_chk = 0, n_bad = 0, cyc = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  pstage_guard i_pstage_guard (
    .clk(clk), .rst(rst), .oc_flag_i(oc), .tj_degc_i(tj), .vsup_dv_i(vs),
    .pdn_n_i(pdn_n), .hiz_n_i(hiz_n), .auto_retry_i(auto_r),
    .retry_len_i(rlen), .out_en_o(en), .fault_n_o(fn), .twarn_n_o(wn)
  );

  // {tj, vs, pdn_n, hiz_n, expected en, expected twarn_n}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {8'd25,  9'd120, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'd130, 9'd120, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'd131, 9'd120, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'd60,  9'd69,  1'b1, 1'b1, 1'b0, 1'b1},
    {8'd60,  9'd70,  1'b1, 1'b1, 1'b1, 1'b1},
    {8'd60,  9'd120, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'd60,  9'd120, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'd149, 9'd120, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'd40,  9'd120, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic chk_n(input string req, input string what,
                       input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic toggle();
    hiz_n = 1'b0; tick();
    hiz_n = 1'b1; tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    int cnt;
    @(negedge clk);
    tick();
    // R1: reset state
    chk("R1", "en in reset", en, 1'b0);
    chk("R1", "fault_n in reset", fn, 1'b1);
    chk("R1", "twarn_n in reset", wn, 1'b1);
    rst = 1'b0;
    tick();
    chk("R1", "en after reset", en, 1'b1);

    // table walk: R6 warning level, R8 undervoltage, R9 gating
    for (int i = 0; i < NV; i++) begin
      {tj, vs, pdn_n, hiz_n} = VEC[i][20:2];
      tick();
      chk("R9", $sformatf("vec %0d en", i), en, VEC[i][1]);
      chk("R6", $sformatf("vec %0d twarn_n", i), wn, VEC[i][0]);
      chk("R8", $sformatf("vec %0d fault_n", i), fn, 1'b1);
    end
    tj = 8'd25; vs = 9'd120; pdn_n = 1'b1; hiz_n = 1'b1;
    tick();

    // R2 / R3: overcurrent pulse
    oc = 4'b0100;
    #1 chk("R2", "en same cycle on overcurrent", en, 1'b0);
    tick();
    oc = '0;
    chk("R3", "fault_n after overcurrent", fn, 1'b0);
    tick(); tick(); tick();
    chk("R4", "fault held while hiz high", fn, 1'b0);
    chk("R4", "en held off while latched", en, 1'b0);
    toggle();
    chk("R4", "fault_n after toggle", fn, 1'b1);
    chk("R4", "en after toggle", en, 1'b1);

    // R5: condition present at release
    oc = 4'b0001;
    tick();
    toggle();
    chk("R5", "fault_n one cycle high", fn, 1'b1);
    chk("R5", "en stays low", en, 1'b0);
    tick();
    chk("R5", "fault relatched", fn, 1'b0);
    oc = '0;
    tick();
    toggle();
    chk("R5", "en after clean release", en, 1'b1);

    // R2 / R7: thermal trip and hysteresis
    tj = 8'd150;
    #1 chk("R2", "en same cycle on thermal trip", en, 1'b0);
    tick();
    chk("R3", "fault_n after thermal trip", fn, 1'b0);
    chk("R6", "twarn_n at trip", wn, 1'b0);
    tj = 8'd140;
    tick(); tick();
    toggle();
    chk("R7", "fault_n brief release in band", fn, 1'b1);
    chk("R7", "en off in band", en, 1'b0);
    tick();
    chk("R7", "relatch at 140", fn, 1'b0);
    tj = 8'd126;
    tick(); tick();
    toggle();
    tick();
    chk("R7", "relatch at 126", fn, 1'b0);
    tj = 8'd125;
    tick(); tick();
    chk("R4", "still latched after cooling", fn, 1'b0);
    toggle();
    chk("R7", "release at 125", fn, 1'b1);
    chk("R7", "en at 125", en, 1'b1);
    chk("R6", "twarn_n at 125", wn, 1'b1);
    tick();
    chk("R7", "stays released", fn, 1'b1);

    // R8: undervoltage does not latch
    vs = 9'd65;
    tick();
    chk("R8", "en off below 7 V", en, 1'b0);
    chk("R8", "no latch on undervoltage", fn, 1'b1);
    vs = 9'd70;
    tick();
    chk("R8", "auto recovery at 7 V", en, 1'b1);

    // R10: self retry
    auto_r = 1'b1; rlen = 12'd5;
    oc = 4'b1000;
    tick();
    oc = '0;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (fn == 1'b0) cnt++;
      tick();
    end
    chk_n("R10", "low cycles len 5", cnt, 6);
    chk("R10", "en after self retry", en, 1'b1);
    rlen = 12'd0;
    oc = 4'b0010;
    tick();
    oc = '0;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (fn == 1'b0) cnt++;
      tick();
    end
    chk_n("R10", "low cycles len 0", cnt, 2);
    auto_r = 1'b0;

    finished = 1;
    summary();
  end
endmodule